// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Register Bus

This block is one general-purpose I/O port of sixteen pins, controlled over a simple single-cycle register bus. Each request carries a byte address, a byte count and, for writes, a data word. Software uses it to drive pin levels and enables, to steer which pins listen to the outside, and to store a 32-bit pin-routing word. The routing word is kept and read back only; it has no effect inside this block.

Pin direction has no address of its own. It changes only through a set alias and a clear alias, and both aliases read back the current direction. Output data can be written directly or changed bit by bit through its own set and clear aliases. Every access is checked for width before its offset is checked, and a rejected access leaves every register untouched. Incoming pin levels pass through a two-flop synchronizer. A synchronized level is accepted into the readable pin state only on pins that are inputs, have input enabled and have the function enabled.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0, and pin_out, pin_oe, pin_state, bus_rdata, bus_err and bus_err_code are all 0.
- R2: The register slots sit at byte offsets 0x00 (function enable), 0x04 (data), 0x08 (data set), 0x0C (data clear), 0x10 (direction set), 0x14 (direction clear), 0x18 (input enable) and 0x1C (routing word). Function enable, data and input enable are 16-bit read/write storage. The routing word is 32-bit read/write storage. A 16-bit read returns the value zero-extended.
- R3: bus_size gives the access size in bytes. Offset 0x1C must be accessed with size 4, and every other address must be accessed with size 2. Any other size reports bus_err_code 1 (width error).
- R4: An access that passes the width check but whose address is not one of the eight slots (any address with a nonzero low two bits) reports bus_err_code 2 (unmapped). The width check takes priority, so an unmapped address with the wrong size reports code 1.
- R5: A rejected access changes no register and no pin output, returns bus_rdata 0, and raises bus_err for exactly one cycle. An accepted access reports bus_err_code 0 and leaves bus_err low.
- R6: A write to data set ORs the written bits into data. A write to data clear clears every data bit written as 1. A read of data, data set or data clear returns the current data.
- R7: Direction is changed only by writes to direction set, which ORs bits in, and to direction clear, which clears the bits written as 1. A read of either alias returns the current direction.
- R8: After an accepted write to data, data set, data clear or direction set, each pin whose input-enable bit is 0 drives its new data bit on pin_out. Pins whose input-enable bit is 1 hold their pin_out value. No other access changes pin_out.
- R9: pin_oe equals direction AND NOT input enable, bit by bit, and follows register changes from the clock edge that performs the write.
- R10: A pin_in level is accepted only when that pin's direction bit is 0, its input-enable bit is 1 and its function-enable bit is 1. An accepted level shows on pin_state on the third rising edge after it is applied. On a pin that is not accepted, pin_state holds its value.
- R11: bus_rdata, bus_err and bus_err_code are registered and describe the request sampled at the previous rising edge. Writes and idle cycles return bus_rdata 0 and bus_err_code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte address inside the port |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the previous request |
| bus_err | output | 1 | One-cycle error pulse for the previous request |
| bus_err_code | output | 2 | 0 ok, 1 width error, 2 unmapped |
| pin_in | input | 16 | Incoming pin levels |
| pin_out | output | 16 | Driven pin levels |
| pin_oe | output | 16 | Per-pin output enable |
| pin_state | output | 16 | Synchronized, gated input levels |

## Verification
The bench builds the block with its default parameters: 16 pins, a 32-bit routing word and a 5-bit address. With these values the whole address space of 32 byte addresses, crossed with sizes 1 to 4, can be swept in full. Each of the 128 combinations is read and also written with a computed pattern, so every width and unmapped case, and the error priority between them, is checked against arithmetic expectations. Three control registers are then loaded with interleaved bit patterns so that the 16 pins cover all eight direction, input-enable and function-enable combinations twice. This lets a few input patterns exercise the acceptance gate and the three-edge latency on every combination.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int NUM_REGS = 8;
    localparam int SLOT_W   = 3;
    localparam int SIZE_W   = 3;

    typedef enum logic [SLOT_W-1:0] {
        REG_FER  = 3'd0,
        REG_DATA = 3'd1,
        REG_SET  = 3'd2,
        REG_CLR  = 3'd3,
        REG_DSET = 3'd4,
        REG_DCLR = 3'd5,
        REG_INEN = 3'd6,
        REG_MUX  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_WIDTH    = 2'd1,
        ERR_UNMAPPED = 2'd2
    } err_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
        err_e     err;
    } bus_cmd_t;

    function automatic logic [SIZE_W-1:0] bytes_needed(input logic is_wide);
        return is_wide ? SIZE_W'(4) : SIZE_W'(2);
    endfunction

    function automatic logic touches_output(input reg_sel_e s);
        return (s == REG_DATA) || (s == REG_SET) || (s == REG_CLR) || (s == REG_DSET);
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output bus_cmd_t          cmd
);

    logic     high_zero;
    logic     aligned;
    logic     is_wide;
    reg_sel_e slot;
    err_e     code;

    generate
        if (ADDR_W > 5) begin : g_high
            assign high_zero = (addr[ADDR_W-1:5] == '0);
        end else begin : g_nohigh
            assign high_zero = 1'b1;
        end
    endgenerate

    assign slot    = reg_sel_e'(addr[4:2]);
    assign aligned = high_zero && (addr[1:0] == 2'b00);
    assign is_wide = aligned && (slot == REG_MUX);

    // width is judged before the offset, so a bad width wins
    always_comb begin
        code = ERR_NONE;
        if (size != bytes_needed(is_wide)) begin
            code = ERR_WIDTH;
        end else if (!aligned) begin
            code = ERR_UNMAPPED;
        end
    end

    always_comb begin
        cmd.rd  = req && !we && (code == ERR_NONE);
        cmd.wr  = req &&  we && (code == ERR_NONE);
        cmd.sel = slot;
        cmd.err = req ? code : ERR_NONE;
    end

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_port_pkg::*;
#(
    parameter int PIN_W = 16,
    parameter int MUX_W = 32,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_cmd_t         cmd,
    input  logic [BUS_W-1:0] wdata,
    output logic [PIN_W-1:0] fer_q,
    output logic [PIN_W-1:0] data_q,
    output logic [PIN_W-1:0] dir_q,
    output logic [PIN_W-1:0] inen_q,
    output logic [MUX_W-1:0] mux_q,
    output logic [PIN_W-1:0] data_nxt,
    output logic             out_upd,
    output logic [BUS_W-1:0] rdata,
    output logic             err,
    output logic [1:0]       err_code
);

    logic [PIN_W-1:0] wpin;
    logic [MUX_W-1:0] wmux;
    logic [PIN_W-1:0] fer_nxt;
    logic [PIN_W-1:0] dir_nxt;
    logic [PIN_W-1:0] inen_nxt;
    logic [MUX_W-1:0] mux_nxt;
    logic [BUS_W-1:0] rd_val;

    assign wpin = wdata[PIN_W-1:0];
    assign wmux = wdata[MUX_W-1:0];

    always_comb begin
        fer_nxt  = fer_q;
        data_nxt = data_q;
        dir_nxt  = dir_q;
        inen_nxt = inen_q;
        mux_nxt  = mux_q;
        if (cmd.wr) begin
            unique case (cmd.sel)
                REG_FER:  fer_nxt  = wpin;
                REG_DATA: data_nxt = wpin;
                REG_SET:  data_nxt = data_q | wpin;
                REG_CLR:  data_nxt = data_q & ~wpin;
                REG_DSET: dir_nxt  = dir_q | wpin;
                REG_DCLR: dir_nxt  = dir_q & ~wpin;
                REG_INEN: inen_nxt = wpin;
                REG_MUX:  mux_nxt  = wmux;
            endcase
        end
    end

    assign out_upd = cmd.wr && touches_output(cmd.sel);

    always_comb begin
        rd_val = '0;
        unique case (cmd.sel)
            REG_FER:                    rd_val = BUS_W'(fer_q);
            REG_DATA, REG_SET, REG_CLR: rd_val = BUS_W'(data_q);
            REG_DSET, REG_DCLR:         rd_val = BUS_W'(dir_q);
            REG_INEN:                   rd_val = BUS_W'(inen_q);
            REG_MUX:                    rd_val = BUS_W'(mux_q);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fer_q    <= '0;
            data_q   <= '0;
            dir_q    <= '0;
            inen_q   <= '0;
            mux_q    <= '0;
            rdata    <= '0;
            err      <= 1'b0;
            err_code <= 2'd0;
        end else begin
            fer_q    <= fer_nxt;
            data_q   <= data_nxt;
            dir_q    <= dir_nxt;
            inen_q   <= inen_nxt;
            mux_q    <= mux_nxt;
            rdata    <= cmd.rd ? rd_val : '0;
            err      <= (cmd.err != ERR_NONE);
            err_code <= cmd.err;
        end
    end

    AST_BAD_ACCESS_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (cmd.err != ERR_NONE) |=> ($stable(fer_q) && $stable(data_q) && $stable(dir_q)
                                   && $stable(inen_q) && $stable(mux_q))); // R5
    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        err |-> (rdata == '0)); // R5
    AST_ERR_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(err_code)); // R4
    AST_DATA_SET_ORS: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == REG_SET) |=> ((data_q & $past(wpin)) == $past(wpin))); // R6
    AST_DATA_CLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == REG_CLR) |=> ((data_q & $past(wpin)) == '0)); // R6
    AST_DIR_SET_ORS: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == REG_DSET) |=> ((dir_q & $past(wpin)) == $past(wpin))); // R7
    AST_DIR_CLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == REG_DCLR) |=> ((dir_q & $past(wpin)) == '0)); // R7

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
    parameter int PIN_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             out_upd,
    input  logic [PIN_W-1:0] data_nxt,
    input  logic [PIN_W-1:0] dir_q,
    input  logic [PIN_W-1:0] inen_q,
    input  logic [PIN_W-1:0] fer_q,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe,
    output logic [PIN_W-1:0] pin_state
);

    logic [PIN_W-1:0] accept;
    logic [PIN_W-1:0] synced;

    assign accept = ~dir_q & inen_q & fer_q;
    assign pin_oe = dir_q & ~inen_q;

    generate
        for (genvar i = 0; i < PIN_W; i++) begin : g_sync
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[SYNC_STAGES-2:0], pin_in[i]};
                end
            end
            assign synced[i] = chain[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_state <= '0;
            pin_out   <= '0;
        end else begin
            pin_state <= (pin_state & ~accept) | (synced & accept);
            if (out_upd) begin
                pin_out <= (pin_out & inen_q) | (data_nxt & ~inen_q);
            end
        end
    end

    AST_IGNORED_PIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pin_state ^ $past(pin_state)) & ~$past(accept)) == '0)); // R10
    AST_OUT_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !out_upd |=> $stable(pin_out)); // R8
    AST_OUT_INEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        out_upd |=> (((pin_out ^ $past(pin_out)) & $past(inen_q)) == '0)); // R8

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int PIN_W       = 16,
    parameter int MUX_W       = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [MUX_W-1:0]  bus_wdata,
    output logic [MUX_W-1:0]  bus_rdata,
    output logic              bus_err,
    output logic [1:0]        bus_err_code,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic [PIN_W-1:0]  pin_state
);

    localparam int BUS_W = MUX_W;

    bus_cmd_t         cmd;
    logic [PIN_W-1:0] fer_q;
    logic [PIN_W-1:0] data_q;
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] inen_q;
    logic [MUX_W-1:0] mux_q;
    logic [PIN_W-1:0] data_nxt;
    logic             out_upd;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req  (bus_req),
        .we   (bus_we),
        .addr (bus_addr),
        .size (bus_size),
        .cmd  (cmd)
    );

    gpio_reg_file #(.PIN_W(PIN_W), .MUX_W(MUX_W), .BUS_W(BUS_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .wdata    (bus_wdata),
        .fer_q    (fer_q),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .inen_q   (inen_q),
        .mux_q    (mux_q),
        .data_nxt (data_nxt),
        .out_upd  (out_upd),
        .rdata    (bus_rdata),
        .err      (bus_err),
        .err_code (bus_err_code)
    );

    gpio_pin_ctrl #(.PIN_W(PIN_W), .SYNC_STAGES(SYNC_STAGES)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .out_upd   (out_upd),
        .data_nxt  (data_nxt),
        .dir_q     (dir_q),
        .inen_q    (inen_q),
        .fer_q     (fer_q),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_state (pin_state)
    );

    AST_ERR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !$past(bus_req)) |-> 1'b0); // R5
    AST_ROUTING_WORD_NO_PIN_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == ADDR_W'(28)) |=> $stable(pin_out)); // R8

endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [1:0]  bus_err_code;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic [15:0] pin_state;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // requirement-level model of the port
    logic [15:0] m_fer, m_data, m_dir, m_inen, m_pout, m_state;
    logic [31:0] m_mux;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_ctrl u0 (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .bus_err_code(bus_err_code),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_state(pin_state)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input logic [4:0] a, input logic [2:0] sz);
        logic [2:0] need;
        need = (a == 5'd28) ? 3'd4 : 3'd2;
        if (sz != need) return 2'd1;
        if (a[1:0] != 2'b00) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic [31:0] model_read(input logic [4:0] a);
        case (a[4:2])
            3'd0:             return {16'h0, m_fer};
            3'd1, 3'd2, 3'd3: return {16'h0, m_data};
            3'd4, 3'd5:       return {16'h0, m_dir};
            3'd6:             return {16'h0, m_inen};
            default:          return m_mux;
        endcase
    endfunction

    task automatic model_write(input logic [4:0] a, input logic [31:0] wd);
        logic [15:0] w;
        w = wd[15:0];
        case (a[4:2])
            3'd0: m_fer  = w;
            3'd1: m_data = w;
            3'd2: m_data = m_data | w;
            3'd3: m_data = m_data & ~w;
            3'd4: m_dir  = m_dir | w;
            3'd5: m_dir  = m_dir & ~w;
            3'd6: m_inen = w;
            default: m_mux = wd;
        endcase
        if (a[4:2] inside {3'd1, 3'd2, 3'd3, 3'd4})
            m_pout = (m_pout & m_inen) | (m_data & ~m_inen);
    endtask

    task automatic xfer(input logic we, input logic [4:0] a, input logic [2:0] sz,
                        input logic [31:0] wd);
        logic [1:0] c;
        @(negedge clk);
        chk("R5 err low between requests", {31'h0, bus_err}, 32'h0);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        c = exp_code(a, sz);
        chk((c == 2'd1) ? "R3 width code" : "R4 offset code", {30'h0, bus_err_code}, {30'h0, c});
        chk("R5 err flag", {31'h0, bus_err}, {31'h0, (c != 2'd0)});
        chk(we ? "R11 write rdata zero" : "R2 read data",
            bus_rdata, (!we && c == 2'd0) ? model_read(a) : 32'h0);
        if (we && c == 2'd0) model_write(a, wd);
        chk("R8 pin_out", {16'h0, pin_out}, {16'h0, m_pout});
        chk("R9 pin_oe", {16'h0, pin_oe}, {16'h0, m_dir & ~m_inen});
    endtask

    task automatic sweep_reads();
        for (int a = 0; a < 32; a++)
            for (int s = 1; s <= 4; s++)
                xfer(1'b0, 5'(a), 3'(s), 32'h0);
    endtask

    initial begin : watchdog
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        m_fer = '0; m_data = '0; m_dir = '0; m_inen = '0; m_pout = '0; m_state = '0; m_mux = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 pin_out", {16'h0, pin_out}, 32'h0);
        chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
        chk("R1 pin_state", {16'h0, pin_state}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 err", {30'h0, bus_err_code, 1'b0} | {31'h0, bus_err}, 32'h0);

        // R3 R4 R5: every address and size on the reset image
        sweep_reads();

        // writes across the whole address map with computed patterns
        for (int a = 0; a < 32; a++)
            for (int s = 1; s <= 4; s++)
                xfer(1'b1, 5'(a), 3'(s), (32'h9E37_79B9 * 32'(a + 1)) ^ (32'h0101_0101 * 32'(s)));
        sweep_reads();

        // R2 plain storage
        xfer(1'b1, 5'h00, 3'd2, 32'h0000_1234);
        xfer(1'b1, 5'h18, 3'd2, 32'hFFFF_0F0F);
        xfer(1'b1, 5'h1C, 3'd4, 32'hDEAD_BEEF);
        xfer(1'b0, 5'h1C, 3'd4, 32'h0);
        chk("R2 routing word", m_mux, 32'hDEAD_BEEF);

        // R6 set/clear aliases
        xfer(1'b1, 5'h04, 3'd2, 32'h0000_00FF);
        xfer(1'b1, 5'h08, 3'd2, 32'h0000_0F00);
        xfer(1'b0, 5'h0C, 3'd2, 32'h0);
        chk("R6 set ORs", {16'h0, m_data}, 32'h0000_0FFF);
        xfer(1'b1, 5'h0C, 3'd2, 32'h0000_00F0);
        xfer(1'b0, 5'h08, 3'd2, 32'h0);
        chk("R6 clear", {16'h0, m_data}, 32'h0000_0F0F);

        // R7 direction aliases
        xfer(1'b1, 5'h14, 3'd2, 32'h0000_FFFF);
        xfer(1'b1, 5'h10, 3'd2, 32'h0000_AAAA);
        xfer(1'b1, 5'h14, 3'd2, 32'h0000_000A);
        xfer(1'b0, 5'h14, 3'd2, 32'h0);
        xfer(1'b0, 5'h10, 3'd2, 32'h0);
        chk("R7 direction", {16'h0, m_dir}, 32'h0000_AAA0);

        // R5 rejected writes leave state
        xfer(1'b1, 5'h04, 3'd4, 32'h0000_FFFF);
        xfer(1'b1, 5'h06, 3'd2, 32'h0000_FFFF);
        xfer(1'b1, 5'h1C, 3'd2, 32'h0000_0000);
        xfer(1'b1, 5'h1E, 3'd4, 32'h0000_0000);
        sweep_reads();

        // R8 input-enabled pins hold pin_out; inen write alone does not update
        xfer(1'b1, 5'h18, 3'd2, 32'h0000_FF00);
        xfer(1'b1, 5'h04, 3'd2, 32'h0000_5A5A);
        xfer(1'b1, 5'h18, 3'd2, 32'h0000_0000);
        chk("R8 pin_out after inen write", {16'h0, pin_out}, {16'h0, m_pout});
        xfer(1'b1, 5'h14, 3'd2, 32'h0000_FFFF);
        xfer(1'b1, 5'h10, 3'd2, 32'h0000_0000);

        // R10 input gating: all 8 control combinations
        xfer(1'b1, 5'h14, 3'd2, 32'h0000_FFFF);
        xfer(1'b1, 5'h10, 3'd2, 32'h0000_AAAA);
        xfer(1'b1, 5'h18, 3'd2, 32'h0000_CCCC);
        xfer(1'b1, 5'h00, 3'd2, 32'h0000_F0F0);
        for (int p = 0; p < 6; p++) begin
            logic [15:0] acc, v;
            acc = ~m_dir & m_inen & m_fer;
            v = 16'(32'hB6D3 * 32'(p + 1) + 32'(p * 4099));
            @(negedge clk);
            pin_in = v;
            @(negedge clk);
            @(negedge clk);
            chk("R10 latency not yet", {16'h0, pin_state}, {16'h0, m_state});
            @(negedge clk);
            m_state = (m_state & ~acc) | (v & acc);
            chk("R10 gated capture", {16'h0, pin_state}, {16'h0, m_state});
        end
        chk("R10 accept mask", {16'h0, ~m_dir & m_inen & m_fer}, 32'h0000_4040);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule